// File: doc/BRIEF.md
# Condition register bitwise logic unit

This unit keeps a 32-bit condition register and changes it one instruction at a time. A bit instruction reads two source bits from the register. Each source is picked by a 5-bit index. The unit combines them with one of eight logical functions, some of which complement an operand or the result. It writes the outcome into a destination bit picked by a third 5-bit index. A field move instruction copies one 4-bit field of the register onto another. Both kinds of instruction use the same write path.

Indices count from the most significant end. Bit index i is vector position 31-i. Field n holds bit indices 4n to 4n+3, which are vector positions 31-4n down to 28-4n. The unit reads the sources from the register value before the clock edge, so a destination may overlap its own sources. After each edge a 32-bit mask shows which bits the instruction just wrote.

Top module: `cr_logic_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `cr_q` and `wr_mask` to zero.
- R2: With `op_valid` high, op code 0 writes A AND B, op code 2 writes A OR B and op code 3 writes A XOR B into the destination bit. A is the bit at `srca_idx`, B is the bit at `srcb_idx` and the destination bit is at `dst_idx`.
- R3: Op code 1 writes NOT(A AND B), op code 4 writes NOT(A OR B) and op code 5 writes NOT(A XOR B) into the destination bit.
- R4: Op code 6 writes A AND (NOT B) and op code 7 writes A OR (NOT B) into the destination bit.
- R5: Bit index i refers to `cr_q[31-i]`, so index 0 is the most significant bit.
- R6: A bit instruction changes only the destination bit. In the cycle after the edge, `wr_mask` has exactly that one bit set.
- R7: Op code 8 copies field `src_fld` onto field `dst_fld`. Field n is `cr_q[31-4n -: 4]`. Only the destination field changes, and `wr_mask` then has exactly those four bits set.
- R8: Sources are read before the write in the same instruction, so a destination equal to a source uses the old value. A field moved onto itself is left unchanged but still shows in the mask.
- R9: While `op_valid` is low, `cr_q` holds its value and `wr_mask` is zero after the edge.
- R10: With `op_valid` high, op codes 9 to 15 leave `cr_q` unchanged and give a zero `wr_mask`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Instruction strobe for this cycle |
| op_code | input | 4 | 0..7 logical bit functions, 8 field move |
| dst_idx | input | 5 | Destination bit index |
| srca_idx | input | 5 | First source bit index |
| srcb_idx | input | 5 | Second source bit index |
| dst_fld | input | 3 | Destination field index (move) |
| src_fld | input | 3 | Source field index (move) |
| cr_q | output | 32 | Condition register contents |
| wr_mask | output | 32 | Bits written by the instruction at the last edge |

## Verification
The register starts at zero, so NAND of two clear bits seeds the first set bits. The other functions are then driven with source pairs that are both set, both clear or mixed. These pairs separate AND from AND-with-complement and OR from OR-with-complement. They also separate each function from its complemented form.

Writes to index 0 and index 31, checked against a full register literal, show that indices count from the most significant end. A NAND of a bit with itself, applied twice, shows that each read takes the value from before the write. Field moves between the top, middle and bottom fields, and one move of a field onto itself, check the nibble placement and the four-bit mask. An idle cycle and the unused op codes check that the register is left unchanged.

// File: rtl/cr_logic_unit.sv
module cr_logic_unit #(
  parameter int FLD_CNT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   op_valid,
  input  logic [3:0]             op_code,
  input  logic [4:0]             dst_idx,
  input  logic [4:0]             srca_idx,
  input  logic [4:0]             srcb_idx,
  input  logic [2:0]             dst_fld,
  input  logic [2:0]             src_fld,
  output logic [FLD_CNT*4-1:0]   cr_q,
  output logic [FLD_CNT*4-1:0]   wr_mask
);
  localparam int FLD_W  = 4;
  localparam int CR_W   = FLD_CNT * FLD_W;
  localparam int IDX_W  = $clog2(CR_W);
  localparam int FSEL_W = $clog2(FLD_CNT);
  localparam logic [3:0] OP_MOVE = 4'd8;

  // indices count from the MSB end
  logic [IDX_W-1:0] pos_a, pos_b, pos_d, fbase_s, fbase_d;
  assign pos_a   = IDX_W'(CR_W - 1) - srca_idx;
  assign pos_b   = IDX_W'(CR_W - 1) - srcb_idx;
  assign pos_d   = IDX_W'(CR_W - 1) - dst_idx;
  assign fbase_s = IDX_W'(FLD_W) * IDX_W'(FSEL_W'(FLD_CNT - 1) - src_fld);
  assign fbase_d = IDX_W'(FLD_W) * IDX_W'(FSEL_W'(FLD_CNT - 1) - dst_fld);

  logic a, b, res;
  logic [FLD_W-1:0] src_nib;
  assign a       = cr_q[pos_a];
  assign b       = cr_q[pos_b];
  assign src_nib = cr_q[fbase_s +: FLD_W];

  always_comb begin
    case (op_code[2:0])
      3'd0: res = a & b;
      3'd1: res = ~(a & b);
      3'd2: res = a | b;
      3'd3: res = a ^ b;
      3'd4: res = ~(a | b);
      3'd5: res = ~(a ^ b);
      3'd6: res = a & ~b;
      3'd7: res = a | ~b;
    endcase
  end

  logic is_bit, is_move;
  logic [CR_W-1:0] bit_mask, fld_mask, mask_c, data_c, cr_n;
  assign is_bit   = op_valid && !op_code[3];
  assign is_move  = op_valid && (op_code == OP_MOVE);
  assign bit_mask = {{(CR_W-1){1'b0}}, 1'b1} << pos_d;
  assign fld_mask = {{(CR_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << fbase_d;
  assign mask_c   = is_bit ? bit_mask : (is_move ? fld_mask : '0);
  assign data_c   = is_move ? {FLD_CNT{src_nib}} : {CR_W{res}};
  assign cr_n     = (cr_q & ~mask_c) | (data_c & mask_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q    <= '0;
      wr_mask <= '0;
    end else begin
      cr_q    <= cr_n;
      wr_mask <= mask_c;
    end
  end
endmodule

module cr_logic_unit_chk #(
  parameter int FLD_CNT = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 op_valid,
  input logic [3:0]           op_code,
  input logic [FLD_CNT*4-1:0] cr_q,
  input logic [FLD_CNT*4-1:0] wr_mask
);
  p_only_masked_change_r6: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> ((cr_q ^ $past(cr_q)) & ~wr_mask) == '0);

  p_bit_mask_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_code[3]) |=> $countones(wr_mask) == 1);

  p_field_mask_four_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd8) |=> $countones(wr_mask) == 4);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(cr_q) && wr_mask == '0));

  p_bad_code_noop_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > 4'd8) |=> ($stable(cr_q) && wr_mask == '0));
endmodule

bind cr_logic_unit cr_logic_unit_chk #(.FLD_CNT(FLD_CNT)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .cr_q(cr_q), .wr_mask(wr_mask)
);

// File: tb/cr_logic_unit_tb.sv
module cr_logic_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [4:0] dst_idx = '0, srca_idx = '0, srcb_idx = '0;
  logic [2:0] dst_fld = '0, src_fld = '0;
  logic [31:0] cr_q, wr_mask;
  logic [31:0] cr_exp;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cr_logic_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .dst_idx(dst_idx), .srca_idx(srca_idx), .srcb_idx(srcb_idx),
    .dst_fld(dst_fld), .src_fld(src_fld), .cr_q(cr_q), .wr_mask(wr_mask)
  );

  // {op, bt, ba, bb, expected bit}
  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    {4'd1, 5'd0,  5'd5,  5'd6,  1'b1},
    {4'd1, 5'd3,  5'd5,  5'd6,  1'b1},
    {4'd2, 5'd7,  5'd0,  5'd9,  1'b1},
    {4'd0, 5'd8,  5'd0,  5'd3,  1'b1},
    {4'd0, 5'd9,  5'd0,  5'd10, 1'b0},
    {4'd3, 5'd10, 5'd0,  5'd3,  1'b0},
    {4'd3, 5'd11, 5'd0,  5'd12, 1'b1},
    {4'd4, 5'd12, 5'd20, 5'd21, 1'b1},
    {4'd4, 5'd13, 5'd0,  5'd21, 1'b0},
    {4'd5, 5'd14, 5'd0,  5'd3,  1'b1},
    {4'd5, 5'd15, 5'd0,  5'd20, 1'b0},
    {4'd6, 5'd16, 5'd0,  5'd20, 1'b1},
    {4'd6, 5'd17, 5'd0,  5'd3,  1'b0},
    {4'd7, 5'd18, 5'd20, 5'd21, 1'b1},
    {4'd7, 5'd19, 5'd20, 5'd0,  1'b0},
    {4'd2, 5'd31, 5'd0,  5'd1,  1'b1},
    {4'd1, 5'd0,  5'd0,  5'd0,  1'b0},
    {4'd1, 5'd0,  5'd0,  5'd0,  1'b1}
  };

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd2, 4'd3: return "R2";
      4'd1, 4'd4, 4'd5: return "R3";
      default:          return "R4";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] op,
                       input logic [4:0] bt, input logic [4:0] ba, input logic [4:0] bb,
                       input logic [2:0] bf, input logic [2:0] bfa);
    @(negedge clk);
    op_valid = v; op_code = op; dst_idx = bt; srca_idx = ba; srcb_idx = bb;
    dst_fld = bf; src_fld = bfa;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "cr after reset", cr_q, 32'h0);
    check("R1", "mask after reset", wr_mask, 32'h0);
    @(negedge clk) rst = 1'b0;
    cr_exp = '0;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op; logic [4:0] bt, ba, bb; logic eb;
      {op, bt, ba, bb, eb} = VEC[i];
      issue(1'b1, op, bt, ba, bb, 3'd0, 3'd0);
      cr_exp[31 - bt] = eb;
      check(tag_of(op), "register after bit op", cr_q, cr_exp);
      check("R6", "one-hot write mask", wr_mask, 32'h1 << (31 - bt));
    end

    // R5 / R8: full literal after the table (index 0 toggled back to 1)
    check("R5", "MSB-first bit layout", cr_q, 32'h919A_A001);

    // R7: field 0 -> field 5
    issue(1'b1, 4'd8, 0, 0, 0, 3'd5, 3'd0);
    check("R7", "move field 0 to 5", cr_q, 32'h919A_A901);
    check("R7", "mask field 5", wr_mask, 32'h0000_0F00);

    // R8: field onto itself
    issue(1'b1, 4'd8, 0, 0, 0, 3'd5, 3'd5);
    check("R8", "self move value", cr_q, 32'h919A_A901);
    check("R8", "self move mask", wr_mask, 32'h0000_0F00);

    // R7: field 7 -> field 0
    issue(1'b1, 4'd8, 0, 0, 0, 3'd0, 3'd7);
    check("R7", "move field 7 to 0", cr_q, 32'h119A_A901);
    check("R7", "mask field 0", wr_mask, 32'hF000_0000);

    // R9: strobe low
    issue(1'b0, 4'd1, 5'd9, 5'd9, 5'd9, 3'd0, 3'd0);
    check("R9", "idle holds register", cr_q, 32'h119A_A901);
    check("R9", "idle mask zero", wr_mask, 32'h0);

    // R10: unused codes
    issue(1'b1, 4'd9, 5'd9, 5'd9, 5'd9, 3'd2, 3'd0);
    check("R10", "code 9 no change", cr_q, 32'h119A_A901);
    check("R10", "code 9 mask zero", wr_mask, 32'h0);
    issue(1'b1, 4'd15, 5'd1, 5'd9, 5'd9, 3'd1, 3'd0);
    check("R10", "code 15 no change", cr_q, 32'h119A_A901);
    check("R10", "code 15 mask zero", wr_mask, 32'h0);

    // R1: reset while running, with a valid op pending
    @(negedge clk);
    rst = 1'b1; op_valid = 1'b1; op_code = 4'd1; dst_idx = 5'd4;
    @(posedge clk); #1;
    check("R1", "mid-run reset cr", cr_q, 32'h0);
    check("R1", "mid-run reset mask", wr_mask, 32'h0);
    @(negedge clk); rst = 1'b0; op_valid = 1'b0;
    @(posedge clk); #1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule